// File: doc/BRIEF.md
# Signed Saturating Integer Multiplier

This block multiplies two signed two's complement integers of equal width and returns a result of that same width. When the exact product does not fit, the result is clamped to the nearest representable value. A positive overflow gives the largest positive value. A negative overflow gives the most negative value. A flag marks every clamped result. The block is purely combinational, so the result follows the operands with no clock and no state.

The full double-width product is never formed. A complemented partial-product array produces only the low WIDTH+1 product bits. It adds a single correction one at column WIDTH and drops every column above it. A separate detector runs in parallel with the array. It converts each operand into sign-relative bits by XOR with its own sign bit. A prefix-OR chain then flags any operand pair whose combined count of leading sign bits is below WIDTH. The top two computed product bits cover the remaining overflow cases. The clamp direction comes from the XOR of the two sign bits.

The block suits datapaths that need a same-width saturated product in a single combinational stage. WIDTH must be at least 4.

Top module: `smul_sat`

## Requirements
- R1: When the exact product A*B lies within [-2^(WIDTH-1), 2^(WIDTH-1)-1], p_sat_o equals that product in two's complement. This includes the exact value -2^(WIDTH-1), which is returned as 1 followed by WIDTH-1 zeros.
- R2: When A*B > 2^(WIDTH-1)-1, p_sat_o is 0 followed by WIDTH-1 ones, and ovf_o is 1.
- R3: When A*B < -2^(WIDTH-1), p_sat_o is 1 followed by WIDTH-1 zeros, and ovf_o is 1.
- R4: When A*B lies within [-2^(WIDTH-1)+1, 2^(WIDTH-1)-1], ovf_o is 0. At exactly -2^(WIDTH-1), ovf_o may be either value, and the result is unchanged.
- R5: The most negative value times itself gives 0 followed by WIDTH-1 ones, with ovf_o = 1.
- R6: The most negative value times -1, in either operand order, gives 0 followed by WIDTH-1 ones, with ovf_o = 1. The most negative value times +1 returns the most negative value.
- R7: When either operand is zero, p_sat_o is zero and ovf_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Signed multiplicand |
| b_i | input | WIDTH | Signed multiplier |
| p_sat_o | output | WIDTH | Saturated signed product |
| ovf_o | output | 1 | High when the result was clamped |

## Verification
The bench runs every operand pair for an 8-bit and a 5-bit instance and compares each result with an arithmetic clamp of the integer product.

- **Corner cases at the negative limit.** The bench targets the three products that involve the most negative operand. Squaring it or multiplying it by -1 must give the positive limit. A detector that counts leading sign bits wrongly would let these pass through as the negative limit. Multiplying it by +1 must not be clamped the wrong way.
- **Products just outside the range.** Products one step beyond either limit catch a detector that uses the wrong pair threshold. Such a detector either misses the overflow or flags results that fit.
- **Dropped correction one.** A missing or misplaced correction one at column WIDTH flips the top computed bit. This corrupts both the pass-through value and the overflow decision, so both checks would fail.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [1:0] {
    SAT_PASS = 2'd0,
    SAT_HI   = 2'd1,
    SAT_LO   = 2'd2
  } sat_pick_e;

  // partial-product bit, inverted when exactly one factor is a sign bit
  function automatic logic pp_bit(input logic x, input logic y, input logic inv);
    return (x & y) ^ inv;
  endfunction

endpackage

// File: rtl/smul_pp_array.sv
module smul_pp_array
  import smul_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = WIDTH + 1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [PW-1:0]    low_o
);

  // correction one in column WIDTH; the one in column 2*WIDTH-1 falls outside
  localparam logic [PW-1:0] CORR = {1'b1, {WIDTH{1'b0}}};

  logic [WIDTH:0][PW-1:0] acc;

  assign acc[0] = CORR;

  for (genvar j = 0; j < WIDTH; j++) begin : g_row
    logic [PW-1:0] bits;
    always_comb begin
      bits = '0;
      for (int i = 0; i < WIDTH; i++) begin
        if (i + j <= WIDTH)
          bits[i+j] = pp_bit(a_i[i], b_i[j],
                             (i == WIDTH - 1) != (j == WIDTH - 1));
      end
    end
    assign acc[j+1] = acc[j] + bits;
  end

  assign low_o = acc[WIDTH];

  always_comb begin
    AST_LSB_PRODUCT: assert (low_o[0] == (a_i[0] & b_i[0]))
      else $error("AST_LSB_PRODUCT: bit 0 mismatch");  // R1
  end

endmodule

// File: rtl/smul_ovf_detect.sv
module smul_ovf_detect #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned MAG = WIDTH - 2
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             top_i,   // product bit WIDTH
  input  logic             msb_i,   // product bit WIDTH-1
  output logic             ovf_o
);

  logic [MAG:1] a_rel, b_rel;
  logic [MAG:1] pre_or, hit;
  logic         unused_lsb;

  assign unused_lsb = a_i[0] ^ b_i[0];

  for (genvar k = 1; k <= MAG; k++) begin : g_rel
    assign a_rel[k] = a_i[k] ^ a_i[WIDTH-1];
    assign b_rel[k] = b_i[k] ^ b_i[WIDTH-1];
  end

  // pair (x,y) with x+y >= WIDTH-1 means too few leading sign bits
  for (genvar y = 1; y <= MAG; y++) begin : g_chain
    if (y == 1) begin : g_first
      assign pre_or[y] = a_rel[MAG];
      assign hit[y]    = pre_or[y] & b_rel[y];
    end else begin : g_next
      assign pre_or[y] = pre_or[y-1] | a_rel[WIDTH-1-y];
      assign hit[y]    = hit[y-1] | (pre_or[y] & b_rel[y]);
    end
  end

  assign ovf_o = hit[MAG] | (top_i ^ msb_i);

  always_comb begin
    if (a_rel == '0 || b_rel == '0) begin
      AST_SMALL_OPERAND: assert (!hit[MAG])
        else $error("AST_SMALL_OPERAND: chain hit with a near-unit operand");  // R4
    end
  end

endmodule

// File: rtl/smul_sat_sel.sv
module smul_sat_sel
  import smul_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] raw_i,
  input  logic             ovf_i,
  input  logic             neg_i,
  output logic [WIDTH-1:0] res_o
);

  localparam logic [WIDTH-1:0] POS_LIM = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_LIM = {1'b1, {(WIDTH-1){1'b0}}};

  sat_pick_e pick;

  always_comb begin
    if (!ovf_i)     pick = SAT_PASS;
    else if (neg_i) pick = SAT_LO;
    else            pick = SAT_HI;
  end

  always_comb begin
    unique case (pick)
      SAT_HI:  res_o = POS_LIM;
      SAT_LO:  res_o = NEG_LIM;
      default: res_o = raw_i;
    endcase
  end

  always_comb begin
    if (ovf_i && !neg_i) begin
      AST_CLAMP_POS: assert (res_o == POS_LIM)
        else $error("AST_CLAMP_POS: wrong positive limit");  // R2
    end
    if (ovf_i && neg_i) begin
      AST_CLAMP_NEG: assert (res_o == NEG_LIM)
        else $error("AST_CLAMP_NEG: wrong negative limit");  // R3
    end
  end

endmodule

// File: rtl/smul_sat.sv
module smul_sat #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] p_sat_o,
  output logic             ovf_o
);

  localparam logic [WIDTH-1:0] POS_LIM = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_LIM = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH:0] low;
  logic           neg;

  assign neg = a_i[WIDTH-1] ^ b_i[WIDTH-1];

  smul_pp_array #(.WIDTH(WIDTH)) pp_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .low_o (low)
  );

  smul_ovf_detect #(.WIDTH(WIDTH)) det_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .top_i (low[WIDTH]),
    .msb_i (low[WIDTH-1]),
    .ovf_o (ovf_o)
  );

  smul_sat_sel #(.WIDTH(WIDTH)) sel_i (
    .raw_i (low[WIDTH-1:0]),
    .ovf_i (ovf_o),
    .neg_i (neg),
    .res_o (p_sat_o)
  );

  always_comb begin
    if (!ovf_o) begin
      AST_NO_OVERFLOW: assert (low[WIDTH] == low[WIDTH-1])
        else $error("AST_NO_OVERFLOW: unflagged product exceeds range");  // R4
    end
    if (a_i == '0 || b_i == '0) begin
      AST_ZERO_OPERAND: assert (!ovf_o && p_sat_o == '0)
        else $error("AST_ZERO_OPERAND: nonzero result");  // R7
    end
    if (a_i == NEG_LIM && b_i == NEG_LIM) begin
      AST_MIN_SQUARED: assert (ovf_o && p_sat_o == POS_LIM)
        else $error("AST_MIN_SQUARED: limit squared not clamped high");  // R5
    end
  end

endmodule

// File: tb/smul_sat_tb_top.sv
module smul_sat_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [7:0] a8 = '0, b8 = '0, p8;
  logic       v8;
  logic [4:0] a5 = '0, b5 = '0, p5;
  logic       v5;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  smul_sat #(.WIDTH(8)) dut_i (.a_i(a8), .b_i(b8), .p_sat_o(p8), .ovf_o(v8));
  smul_sat #(.WIDTH(5)) dut_small_i (.a_i(a5), .b_i(b5), .p_sat_o(p5), .ovf_o(v5));

  task automatic judge(input int w, input int x, input int y,
                       input logic [7:0] got_raw, input logic got_v);
    int lim_hi, lim_lo, prod, expv, got;
    bit ovf_known, exp_ovf;
    string tag;
    lim_hi = (1 << (w - 1)) - 1;
    lim_lo = -(1 << (w - 1));
    prod = x * y;
    got = int'(got_raw) & ((1 << w) - 1);
    if (got >= (1 << (w - 1))) got = got - (1 << w);
    ovf_known = 1'b1;
    if (prod > lim_hi) begin expv = lim_hi; exp_ovf = 1'b1; tag = "R2"; end
    else if (prod < lim_lo) begin expv = lim_lo; exp_ovf = 1'b1; tag = "R3"; end
    else begin
      expv = prod; exp_ovf = 1'b0; tag = "R1";
      if (prod == lim_lo) ovf_known = 1'b0;
    end
    if (x == 0 || y == 0) tag = "R7";
    if (x == lim_lo && y == lim_lo) tag = "R5";
    if ((x == lim_lo && (y == -1 || y == 1)) || (y == lim_lo && (x == -1 || x == 1))) tag = "R6";
    if (tag == "R1" && ovf_known && got_v !== exp_ovf) tag = "R4";
    n_run++;
    if (got != expv || (ovf_known && got_v !== exp_ovf)) begin
      n_fail++;
      $display("FAIL %s w=%0d a=%0d b=%0d: p=%0d ovf=%0b expected p=%0d ovf=%0b",
               tag, w, x, y, got, got_v, expv, exp_ovf);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // idle state: zero operands, R7
    judge(8, 0, 0, p8, v8);
    judge(5, 0, 0, {3'b0, p5}, v5);
    // named corners on the wide instance: R5, R6
    begin
      int pairs [6][2] = '{'{-128, -128}, '{-128, -1}, '{-1, -128},
                           '{-128, 1}, '{1, -128}, '{-128, 0}};
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        a8 = 8'(pairs[k][0]); b8 = 8'(pairs[k][1]);
        #1 judge(8, pairs[k][0], pairs[k][1], p8, v8);
      end
    end
    // exhaustive sweep, 5-bit: R1 R2 R3 R4 R7
    for (int x = -16; x < 16; x++) begin
      for (int y = -16; y < 16; y++) begin
        @(negedge clk);
        a5 = 5'(x); b5 = 5'(y);
        #1 judge(5, x, y, {3'b0, p5}, v5);
      end
    end
    // exhaustive sweep, 8-bit
    for (int x = -128; x < 128; x++) begin
      for (int y = -128; y < 128; y++) begin
        @(negedge clk);
        a8 = 8'(x); b8 = 8'(y);
        #1 judge(8, x, y, p8, v8);
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule